// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Address Sequencer

This block walks through every butterfly of an in-place radix-2 FFT of size N = 2^S. It works stage by stage, in decimation-in-frequency order. For each butterfly it presents two data-memory indices (the upper and lower operand), a twiddle index, and the matching complex twiddle factor. The twiddle factor is read from an internal table of signed Q15 cosine/sine values. An external butterfly datapath consumes these descriptors through a valid/ready handshake.

A single-cycle start pulse launches a full transform. The sequencer raises a flag on the last butterfly of every stage and pulses a completion flag once the final butterfly of the last stage has been accepted. A start pulse that arrives while a transform is running is ignored. The transform size is a parameter from 8 to 1024 points.

Top module: `fft_bfly_seq`

## Requirements
- R1: After the synchronous active-high reset, `valid_o`, `stage_end_o` and `done_o` are all low. They stay low until a start pulse is seen.
- R2: A start pulse seen while idle makes `valid_o` high on the next clock edge. The first descriptor shown is stage 0 with index A = 0, index B = N/2 and twiddle index 0.
- R3: Stages are reported on `stage_o` as s = 0..S-1. Stage s has 2^s groups of 2^(S-1-s) butterflies, and the group is the outer loop. For group j and butterfly i, index A = i + j*2^(S-s) and index B = A + 2^(S-1-s).
- R4: The twiddle index of butterfly i in stage s is i*2^s.
- R5: `tw_word_o` is the table entry for the twiddle index shown in the same cycle. Bits 31:16 hold round(-32768*sin(2*pi*k/N)) and bits 15:0 hold round(32768*cos(2*pi*k/N)), both as 16-bit two's complement. The real part of entry 0 saturates to 32767.
- R6: The sequencer moves to the next descriptor only on a clock edge where `valid_o` and `ready_i` are both high. While `ready_i` is low, every output holds its value.
- R7: `stage_end_o` is high exactly while the last butterfly of a stage is shown.
- R8: On the edge that accepts the last butterfly of stage S-1, `valid_o` falls and `done_o` rises for exactly one cycle.
- R9: A start pulse seen while `valid_o` is high has no effect on the descriptor sequence.
- R10: Within each stage, every index 0..N-1 appears exactly once as either A or B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; launches a transform when idle |
| ready_i | input | 1 | Datapath accepts the current descriptor |
| valid_o | output | 1 | Descriptor outputs are valid |
| idx_a_o | output | S | Upper operand index A |
| idx_b_o | output | S | Lower operand index B |
| tw_idx_o | output | S-1 | Twiddle table index |
| tw_word_o | output | 32 | Twiddle factor, imaginary in 31:16, real in 15:0 |
| stage_o | output | $clog2(S+1) | Current stage number, 0-based |
| stage_end_o | output | 1 | Last butterfly of the current stage |
| done_o | output | 1 | One-cycle pulse after the final butterfly is accepted |

## Verification
Every descriptor output, including the twiddle word, is registered. Each one changes at the edge that samples the start pulse or the accepting handshake. The bench therefore drives inputs and compares outputs on the falling edge. What it sees there belongs to the edge just past, and it has no extra pipeline offset to model.

The done pulse is checked on the falling edge right after the final handshake. Its absence is checked one cycle later. During stalls the bench compares the held descriptor at every cycle, against the nested-loop reference and an independently computed twiddle value. It also counts per-stage index coverage over whole runs that use three different ready patterns.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Q15 twiddle entry k of an n-point transform: {imag, real}
  function automatic logic [31:0] tw_entry(input int k, input int n);
    real th;
    int  re;
    int  im;
    th = 2.0 * PI_R * real'(k) / real'(n);
    re = int'(32768.0 * $cos(th));
    im = int'(-32768.0 * $sin(th));
    if (re > 32767)  re = 32767;
    if (re < -32768) re = -32768;
    if (im > 32767)  im = 32767;
    if (im < -32768) im = -32768;
    return {im[15:0], re[15:0]};
  endfunction

endpackage

// File: rtl/fft_tw_rom.sv
module fft_tw_rom #(
  parameter int N_PTS = 16,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  output logic [31:0]   data_o
);
  localparam int DEPTH = N_PTS / 2;

  logic [31:0] tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam logic [31:0] ENTRY = fft_seq_pkg::tw_entry(k, N_PTS);
    assign tab[k] = ENTRY;
  end

  // synchronous read so the table can map to block RAM
  always_ff @(posedge clk) begin
    data_o <= tab[addr_i];
  end

endmodule

// File: rtl/fft_seq_ctr.sv
module fft_seq_ctr #(
  parameter int S  = 4,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          fire_i,
  output logic          busy_q,
  output logic          nxt_busy,
  output logic [SW-1:0] nxt_st,
  output logic [S-2:0]  nxt_grp,
  output logic [S-2:0]  nxt_bf
);
  localparam int HW = S - 1;

  logic [SW-1:0] st_q;
  logic [HW-1:0] grp_q, bf_q;
  logic [HW-1:0] bf_last, grp_last;
  logic          st_last;

  assign bf_last  = HW'((1 << (S - 1 - int'(st_q))) - 1);
  assign grp_last = HW'((1 << int'(st_q)) - 1);
  assign st_last  = (st_q == SW'(S - 1));

  always_comb begin
    nxt_busy = busy_q;
    nxt_st   = st_q;
    nxt_grp  = grp_q;
    nxt_bf   = bf_q;
    if (!busy_q) begin
      if (start_i) begin
        nxt_busy = 1'b1;
        nxt_st   = '0;
        nxt_grp  = '0;
        nxt_bf   = '0;
      end
    end else if (fire_i) begin
      if (bf_q != bf_last) begin
        nxt_bf = bf_q + 1'b1;
      end else begin
        nxt_bf = '0;
        if (grp_q != grp_last) begin
          nxt_grp = grp_q + 1'b1;
        end else begin
          nxt_grp = '0;
          if (st_last) nxt_busy = 1'b0;
          else         nxt_st   = st_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      st_q   <= '0;
      grp_q  <= '0;
      bf_q   <= '0;
    end else begin
      busy_q <= nxt_busy;
      st_q   <= nxt_st;
      grp_q  <= nxt_grp;
      bf_q   <= nxt_bf;
    end
  end

endmodule

// File: rtl/fft_bfly_seq.sv
module fft_bfly_seq #(
  parameter int N_PTS = 16,
  localparam int S    = $clog2(N_PTS),
  localparam int SW   = $clog2(S + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [S-1:0]  idx_a_o,
  output logic [S-1:0]  idx_b_o,
  output logic [S-2:0]  tw_idx_o,
  output logic [31:0]   tw_word_o,
  output logic [SW-1:0] stage_o,
  output logic          stage_end_o,
  output logic          done_o
);
  localparam int HW = S - 1;

  logic          fire;
  logic          busy_q, nxt_busy;
  logic [SW-1:0] nxt_st;
  logic [HW-1:0] nxt_grp, nxt_bf;
  logic [S-1:0]  a_n, b_n;
  logic [HW-1:0] tw_n;
  logic          end_n;

  assign fire    = busy_q && ready_i;
  assign valid_o = busy_q;

  fft_seq_ctr #(.S(S), .SW(SW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .fire_i   (fire),
    .busy_q   (busy_q),
    .nxt_busy (nxt_busy),
    .nxt_st   (nxt_st),
    .nxt_grp  (nxt_grp),
    .nxt_bf   (nxt_bf)
  );

  // indices for the descriptor that becomes current at the next edge
  assign a_n   = S'(int'(nxt_bf) + (int'(nxt_grp) << (S - int'(nxt_st))));
  assign b_n   = a_n + S'(1 << (S - 1 - int'(nxt_st)));
  assign tw_n  = HW'(int'(nxt_bf) << int'(nxt_st));
  assign end_n = nxt_busy
              && (nxt_bf  == HW'((1 << (S - 1 - int'(nxt_st))) - 1))
              && (nxt_grp == HW'((1 << int'(nxt_st)) - 1));

  fft_tw_rom #(.N_PTS(N_PTS), .AW(HW)) u_rom (
    .clk    (clk),
    .addr_i (tw_n),
    .data_o (tw_word_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_a_o     <= '0;
      idx_b_o     <= '0;
      tw_idx_o    <= '0;
      stage_o     <= '0;
      stage_end_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      idx_a_o     <= a_n;
      idx_b_o     <= b_n;
      tw_idx_o    <= tw_n;
      stage_o     <= nxt_st;
      stage_end_o <= end_n;
      done_o      <= fire && stage_end_o && (stage_o == SW'(S - 1));
    end
  end

  AST_B_ABOVE_A: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (idx_b_o > idx_a_o)); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_a_o) && $stable(idx_b_o)
                                && $stable(tw_idx_o) && $stable(stage_o))); // R6

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && stage_end_o && (stage_o != SW'(S - 1)))
      |=> (valid_o && (stage_o == $past(stage_o) + 1'b1))); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (!valid_o && $past(stage_end_o && ready_i))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (valid_o && start_i && !ready_i) |=> (valid_o && $stable(idx_a_o))); // R9

endmodule

// File: tb/fft_bfly_seq_bench.sv
module fft_bfly_seq_bench;
  localparam int N  = 16;
  localparam int S  = $clog2(N);
  localparam int SW = $clog2(S + 1);
  localparam real PI_R = 3.14159265358979323846;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          ready_i = 1'b0;
  logic          valid_o;
  logic [S-1:0]  idx_a_o, idx_b_o;
  logic [S-2:0]  tw_idx_o;
  logic [31:0]   tw_word_o;
  logic [SW-1:0] stage_o;
  logic          stage_end_o, done_o;

  int checks = 0;
  int errors = 0;
  int seen [S][N];

  always #4 clk = ~clk;

  fft_bfly_seq #(.N_PTS(N)) u_fft_bfly_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ready_i(ready_i),
    .valid_o(valid_o), .idx_a_o(idx_a_o), .idx_b_o(idx_b_o),
    .tw_idx_o(tw_idx_o), .tw_word_o(tw_word_o), .stage_o(stage_o),
    .stage_end_o(stage_end_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_word(input int k);
    real th;
    int  re;
    int  im;
    th = 2.0 * PI_R * real'(k) / real'(N);
    re = int'(32768.0 * $cos(th));
    im = int'(-32768.0 * $sin(th));
    if (re > 32767) re = 32767;
    return int'({im[15:0], re[15:0]});
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", int'(valid_o), 0);
    check("R1 stage_end", int'(stage_end_o), 0);
    check("R1 done", int'(done_o), 0);
  endtask

  // mode 0: ready always; 1: ready every other cycle; 2: ready one cycle in four, start pulsed during stalls
  task automatic t_run(input int mode);
    int cyc = 0;
    for (int s = 0; s < S; s++)
      for (int x = 0; x < N; x++) seen[s][x] = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 valid after start", int'(valid_o), 1);
    for (int s = 0; s < S; s++) begin
      for (int j = 0; j < (1 << s); j++) begin
        for (int i = 0; i < (1 << (S - 1 - s)); i++) begin
          int a = i + j * (1 << (S - s));
          int b = a + (1 << (S - 1 - s));
          int t = i * (1 << s);
          int last = (j == (1 << s) - 1) && (i == (1 << (S - 1 - s)) - 1);
          logic rdy = 1'b0;
          int guard = 0;
          while (!rdy && guard < 64) begin
            check("R6 valid held", int'(valid_o), 1);
            check("R3 index A", int'(idx_a_o), a);
            check("R3 index B", int'(idx_b_o), b);
            check("R3 stage", int'(stage_o), s);
            check("R4 twiddle index", int'(tw_idx_o), t);
            check("R5 twiddle word", int'(tw_word_o), exp_word(t));
            check("R7 stage end", int'(stage_end_o), last);
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(cyc % 2) : 1'(cyc % 4 == 3);
            cyc++;
            ready_i = rdy;
            start_i = (mode == 2) && !rdy;   // R9: ignored while busy
            @(negedge clk);
            guard++;
          end
          seen[s][a]++;
          seen[s][b]++;
        end
      end
    end
    ready_i = 1'b0;
    start_i = 1'b0;
    check("R8 done pulse", int'(done_o), 1);
    check("R8 valid drops", int'(valid_o), 0);
    @(negedge clk);
    check("R8 done one cycle", int'(done_o), 0);
    check("R1 idle stays idle", int'(valid_o), 0);
    for (int s = 0; s < S; s++)
      for (int x = 0; x < N; x++) check("R10 coverage", seen[s][x], 1);
  endtask

  task automatic t_entry0();
    check("R5 entry0 saturated", exp_word(0), 32'h0000_7FFF);
    check("R5 quarter entry", exp_word(N / 4), 32'h8000_0000);
  endtask

  initial begin
    t_reset();
    t_entry0();
    t_run(0);
    t_run(1);
    t_run(2);
    t_reset();
    t_run(0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule